// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Unit

This block keeps the interrupt state of a two-channel IDE controller and drives the single level-sensitive PCI interrupt line. A level input from each channel's drive sets or clears that channel's interrupt flag whenever the level changes. The flag can be read, and cleared by writing a one, in three configuration-space registers: the shared mode register and one mirror register per channel. All three views always show the same value. A blocking mask per channel, held in the mode register, keeps a pending flag from reaching the interrupt line.

Each channel also has a bus-master window of eight bytes; channel 1's window starts 8 bytes above channel 0's. Through its window a channel reaches its bus-master status byte, its UDMA timing byte and the shared mode register. Through the mode register the window can change only the two masks. The status byte holds plain writable bits, write-one-to-clear event bits set by the DMA engine, and a read-only activity bit. Reads at every other offset return all ones. Both access ports are one byte wide, and both return read data combinationally.

Top module: `ide_irq_status_unit`

## Requirements
- R1: After reset, irq_out is 0, every interrupt flag and mask reads 0, and both status bytes and both timing bytes read 0x00 while dma_active is 0.
- R2: On the clock edge after drv_irq[c] changes level, channel c's flag equals the new level. Channel 0's flag is bit 2 of the mode register (cfg 0x71, bus-master offset 1) and bit 2 of its mirror (cfg 0x50). Channel 1's flag is bit 3 of the mode register and bit 4 of its mirror (cfg 0x57).
- R3: A configuration write with a one at a flag's bit position, in any of the three registers, clears that flag in every view. A zero there leaves the flag as it is. Configuration writes change no other bit of these registers, and those other bits read 0 except the masks.
- R4: irq_out = (flag0 AND NOT mask0) OR (flag1 AND NOT mask1), where mask0 is mode bit 4 and mask1 is mode bit 5.
- R5: A bus-master write to offset 1 of either window loads mode bits 5:4 from the data and keeps every other mode bit.
- R6: A bus-master write to status offset 2 of a channel sets bits 6 and 5 from the data, keeps bit 0, and clears bit 1 or bit 2 only where the data has a one. Bits 1 and 2 are set by one-cycle pulses on dma_err_evt and dma_int_evt. Bits 7, 4 and 3 read 0.
- R7: Bit 0 of channel c's status byte reads dma_active[c]. Writes do not change it.
- R8: When a setting event and a clear by writing a one hit the same flag or status bit in the same cycle, the bit ends up set.
- R9: Each channel has its own UDMA timing byte at bus-master offset 3 (address 3 for channel 0, 11 for channel 1). It is written and read back whole, and each channel's byte is independent of the other's.
- R10: Bus-master reads at offsets 0, 4, 5, 6 and 7 of either window return 0xFF, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_irq | input | 2 | Drive interrupt level per channel |
| dma_active | input | 2 | DMA engine activity per channel, shown in status bit 0 |
| dma_err_evt | input | 2 | One-cycle pulse that sets status bit 1 |
| dma_int_evt | input | 2 | One-cycle pulse that sets status bit 2 |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| bm_addr | input | 4 | Bus-master address; bit 3 selects the channel |
| bm_wr | input | 1 | Bus-master write strobe |
| bm_wdata | input | 8 | Bus-master write data |
| bm_rdata | output | 8 | Bus-master read data (combinational) |
| irq_out | output | 1 | Level-sensitive PCI interrupt line |

## Verification
A flag that drifts from its mirror, or a mask that is lost, shows up in the very next read of the mode or mirror register. A wrong clear priority shows up as irq_out dropping in the cycle after a write that overlaps an interrupt. A bit left behind after a partial status write shows up in the next read of that channel's status byte, so every check reads back through the ports one cycle after the stimulus. The benches also write one channel and then read the other, which catches a window that decodes the wrong channel.

// File: rtl/ide_irq_status_unit.sv
module ide_irq_status_unit #(
  parameter logic [7:0] MODE_OFS    = 8'h71,
  parameter logic [7:0] CH0_MIR_OFS = 8'h50,
  parameter logic [7:0] CH1_MIR_OFS = 8'h57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] drv_irq,
  input  logic [1:0] dma_active,
  input  logic [1:0] dma_err_evt,
  input  logic [1:0] dma_int_evt,
  input  logic [7:0] cfg_addr,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic [3:0] bm_addr,
  input  logic       bm_wr,
  input  logic [7:0] bm_wdata,
  output logic [7:0] bm_rdata,
  output logic       irq_out
);
  localparam logic [2:0] BM_MODE = 3'd1;
  localparam logic [2:0] BM_STAT = 3'd2;
  localparam logic [2:0] BM_TIM  = 3'd3;

  logic [1:0] drv_q, flag, mask;
  logic [1:0] st_err, st_int, st_b5, st_b6;
  logic [7:0] tim [2];
  logic [1:0] drv_chg, cfg_clr, wr_stat, wr_tim;
  logic       bm_ch;
  logic [2:0] bm_ofs;
  logic [7:0] mode_val, stat_val;

  assign bm_ch   = bm_addr[3];
  assign bm_ofs  = bm_addr[2:0];
  assign drv_chg = drv_irq ^ drv_q;

  assign cfg_clr[0] = cfg_wr && cfg_wdata[2] &&
                      (cfg_addr == MODE_OFS || cfg_addr == CH0_MIR_OFS);
  assign cfg_clr[1] = cfg_wr && ((cfg_addr == MODE_OFS && cfg_wdata[3]) ||
                                 (cfg_addr == CH1_MIR_OFS && cfg_wdata[4]));

  assign wr_stat[0] = bm_wr && bm_ofs == BM_STAT && !bm_ch;
  assign wr_stat[1] = bm_wr && bm_ofs == BM_STAT &&  bm_ch;
  assign wr_tim[0]  = bm_wr && bm_ofs == BM_TIM  && !bm_ch;
  assign wr_tim[1]  = bm_wr && bm_ofs == BM_TIM  &&  bm_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q  <= '0;
      flag   <= '0;
      mask   <= '0;
      st_err <= '0;
      st_int <= '0;
      st_b5  <= '0;
      st_b6  <= '0;
      tim[0] <= '0;
      tim[1] <= '0;
    end else begin
      drv_q <= drv_irq;
      if (bm_wr && bm_ofs == BM_MODE) mask <= bm_wdata[5:4];
      for (int c = 0; c < 2; c++) begin
        if (drv_chg[c])      flag[c] <= drv_irq[c];
        else if (cfg_clr[c]) flag[c] <= 1'b0;
        st_err[c] <= dma_err_evt[c] | (st_err[c] & ~(wr_stat[c] & bm_wdata[1]));
        st_int[c] <= dma_int_evt[c] | (st_int[c] & ~(wr_stat[c] & bm_wdata[2]));
        if (wr_stat[c]) begin
          st_b5[c] <= bm_wdata[5];
          st_b6[c] <= bm_wdata[6];
        end
        if (wr_tim[c]) tim[c] <= bm_wdata;
      end
    end
  end

  assign mode_val = {2'b00, mask, flag, 2'b00};
  assign stat_val = {1'b0, st_b6[bm_ch], st_b5[bm_ch], 2'b00,
                     st_int[bm_ch], st_err[bm_ch], dma_active[bm_ch]};

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_addr == MODE_OFS)         cfg_rdata = mode_val;
    else if (cfg_addr == CH0_MIR_OFS) cfg_rdata = {5'b0, flag[0], 2'b0};
    else if (cfg_addr == CH1_MIR_OFS) cfg_rdata = {3'b0, flag[1], 4'b0};
  end

  always_comb begin
    case (bm_ofs)
      BM_MODE: bm_rdata = mode_val;
      BM_STAT: bm_rdata = stat_val;
      BM_TIM:  bm_rdata = tim[bm_ch];
      default: bm_rdata = 8'hFF;
    endcase
  end

  assign irq_out = (flag[0] & ~mask[0]) | (flag[1] & ~mask[1]);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[7:5], cfg_wdata[1:0]};

  p_drive_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_chg[0] |=> flag[0] == $past(drv_irq[0]));
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clr[1] && !drv_chg[1]) |=> !flag[1]);
  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq_out);
  p_no_flag_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flag) |-> !irq_out);
  p_stat_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat[0] && !bm_wdata[2] && !dma_int_evt[0]) |=> $stable(st_int[0]));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_chg[0] && drv_irq[0] && cfg_clr[0]) |=> flag[0]);
endmodule

// File: tb/tb_ide_irq_status_unit.sv
module tb_ide_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MODE = 8'h71, MIR0 = 8'h50, MIR1 = 8'h57;

  logic clk = 0, rst_n = 0;
  logic [1:0] drv_irq = 0, dma_active = 0, dma_err_evt = 0, dma_int_evt = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, bm_wdata = 0;
  logic cfg_wr = 0, bm_wr = 0;
  logic [3:0] bm_addr = 0;
  logic [7:0] cfg_rdata, bm_rdata;
  logic irq_out;
  int checks = 0, fails = 0;

  ide_irq_status_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic cfg_rd(logic [7:0] a, output logic [7:0] d);
    cfg_addr = a; #1 d = cfg_rdata;
  endtask
  task automatic bm_rd(logic [3:0] a, output logic [7:0] d);
    bm_addr = a; #1 d = bm_rdata;
  endtask
  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1; step(); cfg_wr = 0;
  endtask
  task automatic bm_write(logic [3:0] a, logic [7:0] d);
    bm_addr = a; bm_wdata = d; bm_wr = 1; step(); bm_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    cfg_rd(MODE, d); chk("R1 mode", d, 8'h00);
    bm_rd(4'd2, d);  chk("R1 stat0", d, 8'h00);
    bm_rd(4'd11, d); chk("R1 tim1", d, 8'h00);
  endtask

  task automatic t_drive();
    logic [7:0] d;
    drv_irq[0] = 1; step();
    cfg_rd(MODE, d); chk("R2 mode ch0", d, 8'h04);
    cfg_rd(MIR0, d); chk("R2 mirror ch0", d, 8'h04);
    chk("R4 irq ch0", {7'b0, irq_out}, 8'h01);
    drv_irq[1] = 1; step();
    cfg_rd(MIR1, d); chk("R2 mirror ch1", d, 8'h10);
    drv_irq[0] = 0; step();
    bm_rd(4'd1, d); chk("R2 mode after ch0 drop", d, 8'h08);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    cfg_write(MIR1, 8'h10);
    cfg_rd(MODE, d); chk("R3 mirror clear reaches mode", d, 8'h00);
    chk("R3 irq off", {7'b0, irq_out}, 8'h00);
    drv_irq[0] = 1; step();
    cfg_write(MODE, 8'h00);
    cfg_rd(MIR0, d); chk("R3 zero keeps flag", d, 8'h04);
    cfg_write(MIR0, 8'hFB);
    cfg_rd(MIR0, d); chk("R3 other bits not writable", d, 8'h04);
    cfg_write(MODE, 8'h34);
    cfg_rd(MIR0, d); chk("R3 mode clear reaches mirror", d, 8'h00);
    cfg_rd(MODE, d); chk("R3 masks not cfg writable", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    drv_irq[0] = 0; step(); drv_irq[0] = 1; step();
    bm_write(4'd1, 8'h10);
    bm_rd(4'd1, d); chk("R5 mask write keeps flag", d, 8'h14);
    chk("R4 masked ch0", {7'b0, irq_out}, 8'h00);
    bm_write(4'd1, 8'hCF);
    cfg_rd(MODE, d); chk("R5 only bits 5:4", d, 8'h04);
    bm_write(4'd9, 8'h30);
    drv_irq[1] = 0; step(); drv_irq[1] = 1; step();
    cfg_rd(MODE, d); chk("R5 ch1 window", d, 8'h3C);
    chk("R4 both masked", {7'b0, irq_out}, 8'h00);
    bm_write(4'd1, 8'h20);
    chk("R4 ch0 unmasked", {7'b0, irq_out}, 8'h01);
    bm_write(4'd1, 8'h00);
    cfg_write(MODE, 8'h0C);
    chk("R4 cleared", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    drv_irq[0] = 0; step();
    drv_irq[0] = 1; cfg_write(MODE, 8'h04);
    cfg_rd(MODE, d); chk("R8 drive set beats clear", d, 8'h04);
    chk("R8 irq kept", {7'b0, irq_out}, 8'h01);
    cfg_write(MIR0, 8'h04);
    dma_int_evt[0] = 1; bm_write(4'd2, 8'h04); dma_int_evt[0] = 0;
    bm_rd(4'd2, d); chk("R8 status event beats clear", d, 8'h04);
    bm_write(4'd2, 8'h04);
  endtask

  task automatic t_status();
    logic [7:0] d;
    dma_active = 2'b01; #1;
    bm_rd(4'd2, d);  chk("R7 active ch0", d, 8'h01);
    bm_rd(4'd10, d); chk("R7 ch1 idle", d, 8'h00);
    dma_err_evt[0] = 1; dma_int_evt[0] = 1; step();
    dma_err_evt[0] = 0; dma_int_evt[0] = 0;
    bm_rd(4'd2, d); chk("R6 events set", d, 8'h07);
    bm_write(4'd2, 8'hFE);
    bm_rd(4'd2, d); chk("R6 write FE", d, 8'h61);
    dma_err_evt[0] = 1; step(); dma_err_evt[0] = 0;
    bm_write(4'd2, 8'h00);
    bm_rd(4'd2, d); chk("R6 zero keeps bit1", d, 8'h03);
    bm_write(4'd2, 8'h02);
    bm_rd(4'd2, d); chk("R6 clear bit1", d, 8'h01);
    bm_write(4'd10, 8'h41);
    bm_rd(4'd10, d); chk("R7 bit0 read-only", d, 8'h40);
    bm_rd(4'd2, d);  chk("R6 ch0 untouched", d, 8'h01);
    dma_active = 0;
  endtask

  task automatic t_timing();
    logic [7:0] d;
    bm_write(4'd3, 8'hA5);
    bm_write(4'd11, 8'h3C);
    bm_rd(4'd3, d);  chk("R9 tim0", d, 8'hA5);
    bm_rd(4'd11, d); chk("R9 tim1", d, 8'h3C);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    bm_rd(4'd0, d);  chk("R10 off0", d, 8'hFF);
    bm_rd(4'd4, d);  chk("R10 off4", d, 8'hFF);
    bm_rd(4'd15, d); chk("R10 off15", d, 8'hFF);
    bm_write(4'd4, 8'h00);
    bm_write(4'd12, 8'h00);
    bm_rd(4'd3, d);  chk("R10 tim0 unchanged", d, 8'hA5);
    bm_rd(4'd11, d); chk("R10 tim1 unchanged", d, 8'h3C);
    bm_rd(4'd10, d); chk("R10 stat1 unchanged", d, 8'h40);
  endtask

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset();
    t_drive();
    t_w1c();
    t_mask();
    t_set_wins();
    t_status();
    t_timing();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule